// File: doc/BRIEF.md
# Speculative Reorder Buffer

This block is the in-order retirement queue of an out-of-order core. Each issued instruction claims one slot at the tail of a circular buffer, and the slot index becomes the instruction's tag. Execution units report results against that tag in any order. Until the instruction retires, the result waits in the slot, and younger instructions can read it early through two operand lookup ports. Registers and memory are never written speculatively.

Retirement happens at the head, one slot per cycle, in program order and only once the head slot has its result. A retiring register-writing instruction drives a register file write and a retiring store releases the store path. A retiring branch that was marked mispredicted raises flush and discards every younger slot. A slot marked with an exception writes nothing when it reaches the head: it raises the exception output and also flushes everything.

Top module: `spec_retire_queue`

## Requirements
- R1: While reset is held and right after it, the buffer is empty: commit_valid, flush and exc_raise are 0 and the first granted allocation gets index 0.
- R2: A granted allocation returns the current tail index, and indices advance by one and wrap from DEPTH-1 to 0. A request is refused (alloc_grant 0) while DEPTH slots are occupied.
- R3: At most one slot retires per cycle, in allocation order, and only when the head slot has completed. A completed younger slot waits behind an incomplete head, and commit is idle when the buffer is empty.
- R4: A retiring slot presents its kind, destination and value. Kind code 0 (register write) asserts commit_reg_we, kind code 1 (store) asserts commit_store, and kind code 2 (branch) asserts neither.
- R5: An operand lookup reports ready with the stored value for an in-flight slot that has completed, and not ready for one that has not completed.
- R6: A completion written in a cycle is visible on an operand lookup of the same slot in that same cycle.
- R7: When a branch slot whose completion carried the mispredict bit retires, flush is 1 in that cycle, all younger slots are discarded, and the next allocation index is the branch index plus one.
- R8: When a slot whose completion carried the exception bit retires, exc_raise and flush are 1, neither commit_reg_we nor commit_store is asserted, and all remaining slots are discarded.
- R9: A completion aimed at a slot that is not in flight is ignored: a later lookup of that slot stays not ready.
- R10: No allocation is granted in a cycle in which flush is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_req | input | 1 | Request a slot for a newly issued instruction |
| alloc_kind | input | 2 | Kind: 0 register write, 1 store, 2 branch |
| alloc_dst | input | RW | Destination architectural register |
| alloc_grant | output | 1 | Request accepted this cycle |
| alloc_idx | output | IW | Slot index given to the request (current tail) |
| cmpl_en | input | 1 | A result is being written |
| cmpl_idx | input | IW | Slot the result belongs to |
| cmpl_value | input | DW | Result value |
| cmpl_mispredict | input | 1 | Branch turned out mispredicted |
| cmpl_exception | input | 1 | Instruction faulted |
| look_a_idx | input | IW | Slot read by operand port A |
| look_a_ready | output | 1 | Port A slot has its result |
| look_a_value | output | DW | Port A result |
| look_b_idx | input | IW | Slot read by operand port B |
| look_b_ready | output | 1 | Port B slot has its result |
| look_b_value | output | DW | Port B result |
| commit_valid | output | 1 | Head slot retires this cycle |
| commit_kind | output | 2 | Kind of the retiring slot |
| commit_dst | output | RW | Destination of the retiring slot |
| commit_value | output | DW | Value of the retiring slot |
| commit_reg_we | output | 1 | Register file write enable |
| commit_store | output | 1 | Store release to the memory path |
| flush | output | 1 | Discard all younger speculative work |
| exc_raise | output | 1 | Exception taken at retirement |

## Verification
Two collisions get their own cycles. A completion and an operand lookup hit the same slot: the bench reads the slot on port A while writing its result, and expects ready and the new value before the write is registered. A mispredicted branch retires while a completion to a younger slot and a fresh allocation request arrive together: the bench expects flush, a refused grant and a forwarded lookup in that cycle, and one cycle later the younger slot reads not ready and the next index is the branch index plus one. A scoreboard holds the expected retirement records in program order and compares every retiring slot against the next one.

// File: rtl/rq_pkg.sv
package rq_pkg;
    typedef enum logic [1:0] {
        RQ_REG    = 2'd0,
        RQ_STORE  = 2'd1,
        RQ_BRANCH = 2'd2,
        RQ_RSVD   = 2'd3
    } rq_kind_e;
endpackage

// File: rtl/rq_entries.sv
module rq_entries
    import rq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int DW    = 32,
    parameter int RW    = 5,
    localparam int IW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      alloc_en,
    input  rq_kind_e                  alloc_kind,
    input  logic [RW-1:0]             alloc_dst,
    input  logic                      cmpl_en,
    input  logic [IW-1:0]             cmpl_idx,
    input  logic [DW-1:0]             cmpl_value,
    input  logic                      cmpl_mis,
    input  logic                      cmpl_exc,
    input  logic                      retire_en,
    input  logic                      squash_en,
    output logic [DEPTH-1:0]          vld_o,
    output logic [DEPTH-1:0]          rdy_o,
    output logic [DEPTH-1:0]          mis_o,
    output logic [DEPTH-1:0]          exc_o,
    output rq_kind_e [DEPTH-1:0]      kind_o,
    output logic [DEPTH-1:0][RW-1:0]  dst_o,
    output logic [DEPTH-1:0][DW-1:0]  val_o,
    output logic [IW-1:0]             head_o,
    output logic [IW-1:0]             tail_o,
    output logic [CW-1:0]             occ_o
);
    typedef struct packed {
        logic [DEPTH-1:0]          vld;
        logic [DEPTH-1:0]          rdy;
        logic [DEPTH-1:0]          mis;
        logic [DEPTH-1:0]          exc;
        rq_kind_e [DEPTH-1:0]      kind;
        logic [DEPTH-1:0][RW-1:0]  dst;
        logic [DEPTH-1:0][DW-1:0]  val;
        logic [IW-1:0]             head;
        logic [IW-1:0]             tail;
        logic [CW-1:0]             occ;
    } st_t;

    st_t st_d, st_q;

    function automatic logic [IW-1:0] bump(input logic [IW-1:0] p);
        return (p == IW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d = st_q;
        // result capture, only for slots in flight
        if (cmpl_en && st_q.vld[cmpl_idx]) begin
            st_d.rdy[cmpl_idx] = 1'b1;
            st_d.val[cmpl_idx] = cmpl_value;
            st_d.mis[cmpl_idx] = cmpl_mis;
            st_d.exc[cmpl_idx] = cmpl_exc;
        end
        if (retire_en) begin
            st_d.vld[st_q.head] = 1'b0;
            st_d.head           = bump(st_q.head);
        end
        if (alloc_en) begin
            st_d.vld[st_q.tail]  = 1'b1;
            st_d.rdy[st_q.tail]  = 1'b0;
            st_d.mis[st_q.tail]  = 1'b0;
            st_d.exc[st_q.tail]  = 1'b0;
            st_d.kind[st_q.tail] = alloc_kind;
            st_d.dst[st_q.tail]  = alloc_dst;
            st_d.val[st_q.tail]  = '0;
            st_d.tail            = bump(st_q.tail);
        end
        st_d.occ = st_q.occ + CW'(alloc_en) - CW'(retire_en);
        // discard everything younger than the retiring head
        if (squash_en) begin
            st_d.vld  = '0;
            st_d.tail = bump(st_q.head);
            st_d.occ  = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign vld_o  = st_q.vld;
    assign rdy_o  = st_q.rdy;
    assign mis_o  = st_q.mis;
    assign exc_o  = st_q.exc;
    assign kind_o = st_q.kind;
    assign dst_o  = st_q.dst;
    assign val_o  = st_q.val;
    assign head_o = st_q.head;
    assign tail_o = st_q.tail;
    assign occ_o  = st_q.occ;
endmodule

// File: rtl/rq_lookup.sv
module rq_lookup #(
    parameter int DEPTH = 8,
    parameter int DW    = 32,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic [IW-1:0]            idx,
    input  logic [DEPTH-1:0]         vld,
    input  logic [DEPTH-1:0]         rdy,
    input  logic [DEPTH-1:0][DW-1:0] val,
    input  logic                     cmpl_en,
    input  logic [IW-1:0]            cmpl_idx,
    input  logic [DW-1:0]            cmpl_value,
    output logic                     ready,
    output logic [DW-1:0]            value
);
    logic bypass;

    always_comb begin
        bypass = cmpl_en && (cmpl_idx == idx);
        ready  = vld[idx] && (rdy[idx] || bypass);
        value  = bypass ? cmpl_value : val[idx];
    end
endmodule

// File: rtl/rq_retire.sv
module rq_retire
    import rq_pkg::*;
(
    input  logic     occ_nz,
    input  logic     hd_vld,
    input  logic     hd_rdy,
    input  rq_kind_e hd_kind,
    input  logic     hd_mis,
    input  logic     hd_exc,
    output logic     retire,
    output logic     reg_we,
    output logic     store,
    output logic     squash,
    output logic     exc_raise
);
    always_comb begin
        retire    = occ_nz && hd_vld && hd_rdy;
        exc_raise = retire && hd_exc;
        reg_we    = retire && !hd_exc && (hd_kind == RQ_REG);
        store     = retire && !hd_exc && (hd_kind == RQ_STORE);
        squash    = exc_raise || (retire && (hd_kind == RQ_BRANCH) && hd_mis);
    end
endmodule

// File: rtl/spec_retire_queue.sv
module spec_retire_queue
    import rq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int DW    = 32,
    parameter int RW    = 5,
    localparam int IW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          alloc_req,
    input  logic [1:0]    alloc_kind,
    input  logic [RW-1:0] alloc_dst,
    output logic          alloc_grant,
    output logic [IW-1:0] alloc_idx,
    input  logic          cmpl_en,
    input  logic [IW-1:0] cmpl_idx,
    input  logic [DW-1:0] cmpl_value,
    input  logic          cmpl_mispredict,
    input  logic          cmpl_exception,
    input  logic [IW-1:0] look_a_idx,
    output logic          look_a_ready,
    output logic [DW-1:0] look_a_value,
    input  logic [IW-1:0] look_b_idx,
    output logic          look_b_ready,
    output logic [DW-1:0] look_b_value,
    output logic          commit_valid,
    output logic [1:0]    commit_kind,
    output logic [RW-1:0] commit_dst,
    output logic [DW-1:0] commit_value,
    output logic          commit_reg_we,
    output logic          commit_store,
    output logic          flush,
    output logic          exc_raise
);
    localparam int NLOOK = 2;

    logic [DEPTH-1:0]          vld, rdy, mis, exc;
    rq_kind_e [DEPTH-1:0]      kind;
    logic [DEPTH-1:0][RW-1:0]  dst;
    logic [DEPTH-1:0][DW-1:0]  val;
    logic [IW-1:0]             head, tail;
    logic [CW-1:0]             occ;
    logic                      retire;
    logic                      alloc_en;

    assign alloc_en    = alloc_req && (occ != CW'(DEPTH)) && !flush;
    assign alloc_grant = alloc_en;
    assign alloc_idx   = tail;

    rq_entries #(.DEPTH(DEPTH), .DW(DW), .RW(RW)) u_entries (
        .clk        (clk),
        .rst_n      (rst_n),
        .alloc_en   (alloc_en),
        .alloc_kind (rq_kind_e'(alloc_kind)),
        .alloc_dst  (alloc_dst),
        .cmpl_en    (cmpl_en),
        .cmpl_idx   (cmpl_idx),
        .cmpl_value (cmpl_value),
        .cmpl_mis   (cmpl_mispredict),
        .cmpl_exc   (cmpl_exception),
        .retire_en  (retire),
        .squash_en  (flush),
        .vld_o      (vld),
        .rdy_o      (rdy),
        .mis_o      (mis),
        .exc_o      (exc),
        .kind_o     (kind),
        .dst_o      (dst),
        .val_o      (val),
        .head_o     (head),
        .tail_o     (tail),
        .occ_o      (occ)
    );

    rq_retire u_retire (
        .occ_nz    (occ != '0),
        .hd_vld    (vld[head]),
        .hd_rdy    (rdy[head]),
        .hd_kind   (kind[head]),
        .hd_mis    (mis[head]),
        .hd_exc    (exc[head]),
        .retire    (retire),
        .reg_we    (commit_reg_we),
        .store     (commit_store),
        .squash    (flush),
        .exc_raise (exc_raise)
    );

    assign commit_valid = retire;
    assign commit_kind  = kind[head];
    assign commit_dst   = dst[head];
    assign commit_value = val[head];

    logic [NLOOK-1:0][IW-1:0] lk_idx;
    logic [NLOOK-1:0]         lk_rdy;
    logic [NLOOK-1:0][DW-1:0] lk_val;

    assign lk_idx[0] = look_a_idx;
    assign lk_idx[1] = look_b_idx;

    for (genvar g = 0; g < NLOOK; g++) begin : g_look
        rq_lookup #(.DEPTH(DEPTH), .DW(DW)) u_look (
            .idx        (lk_idx[g]),
            .vld        (vld),
            .rdy        (rdy),
            .val        (val),
            .cmpl_en    (cmpl_en),
            .cmpl_idx   (cmpl_idx),
            .cmpl_value (cmpl_value),
            .ready      (lk_rdy[g]),
            .value      (lk_val[g])
        );
    end

    assign look_a_ready = lk_rdy[0];
    assign look_a_value = lk_val[0];
    assign look_b_ready = lk_rdy[1];
    assign look_b_value = lk_val[1];
endmodule

// File: rtl/rq_checks.sv
module rq_checks #(
    parameter int DEPTH = 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          alloc_grant,
    input logic          commit_valid,
    input logic          commit_reg_we,
    input logic          commit_store,
    input logic          flush,
    input logic          exc_raise,
    input logic [CW-1:0] occ
);
    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= CW'(DEPTH));

    assert_grant_counts_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_grant && !commit_valid) |=> (occ == $past(occ) + 1'b1));

    assert_idle_when_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == '0) |-> !commit_valid);

    assert_retire_counts_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_valid && !flush && !alloc_grant) |=> (occ == $past(occ) - 1'b1));

    assert_single_effect_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({commit_reg_we, commit_store}));

    assert_flush_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (occ == '0));

    assert_exc_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
        exc_raise |-> (flush && !commit_reg_we && !commit_store));

    assert_flush_blocks_alloc_R10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> !alloc_grant);
endmodule

bind spec_retire_queue rq_checks #(.DEPTH(DEPTH)) u_checks (
    .clk           (clk),
    .rst_n         (rst_n),
    .alloc_grant   (alloc_grant),
    .commit_valid  (commit_valid),
    .commit_reg_we (commit_reg_we),
    .commit_store  (commit_store),
    .flush         (flush),
    .exc_raise     (exc_raise),
    .occ           (occ)
);

// File: tb/tb_spec_retire_queue.sv
`timescale 1ns/1ps
module tb_spec_retire_queue;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        alloc_req = 1'b0;
    logic [1:0]  alloc_kind = '0;
    logic [4:0]  alloc_dst = '0;
    logic        alloc_grant;
    logic [2:0]  alloc_idx;
    logic        cmpl_en = 1'b0;
    logic [2:0]  cmpl_idx = '0;
    logic [31:0] cmpl_value = '0;
    logic        cmpl_mispredict = 1'b0;
    logic        cmpl_exception = 1'b0;
    logic [2:0]  look_a_idx = '0;
    logic        look_a_ready;
    logic [31:0] look_a_value;
    logic [2:0]  look_b_idx = '0;
    logic        look_b_ready;
    logic [31:0] look_b_value;
    logic        commit_valid;
    logic [1:0]  commit_kind;
    logic [4:0]  commit_dst;
    logic [31:0] commit_value;
    logic        commit_reg_we;
    logic        commit_store;
    logic        flush;
    logic        exc_raise;

    int n_chk = 0;
    int n_fail = 0;

    // expected retirement record: kind, dst, value, we, store, flush, exc
    logic [42:0] sb[$];

    always #5 clk = ~clk;

    spec_retire_queue dut (
        .clk(clk), .rst_n(rst_n),
        .alloc_req(alloc_req), .alloc_kind(alloc_kind), .alloc_dst(alloc_dst),
        .alloc_grant(alloc_grant), .alloc_idx(alloc_idx),
        .cmpl_en(cmpl_en), .cmpl_idx(cmpl_idx), .cmpl_value(cmpl_value),
        .cmpl_mispredict(cmpl_mispredict), .cmpl_exception(cmpl_exception),
        .look_a_idx(look_a_idx), .look_a_ready(look_a_ready), .look_a_value(look_a_value),
        .look_b_idx(look_b_idx), .look_b_ready(look_b_ready), .look_b_value(look_b_value),
        .commit_valid(commit_valid), .commit_kind(commit_kind), .commit_dst(commit_dst),
        .commit_value(commit_value), .commit_reg_we(commit_reg_we),
        .commit_store(commit_store), .flush(flush), .exc_raise(exc_raise)
    );

    task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic clr();
        alloc_req = 0; alloc_kind = 0; alloc_dst = 0;
        cmpl_en = 0; cmpl_idx = 0; cmpl_value = 0;
        cmpl_mispredict = 0; cmpl_exception = 0;
        look_a_idx = 0; look_b_idx = 0;
    endtask

    task automatic alloc(input logic [1:0] k, input logic [4:0] d, input logic [2:0] exp_idx);
        @(negedge clk); clr();
        alloc_req = 1; alloc_kind = k; alloc_dst = d;
        #2;
        chk(alloc_grant && alloc_idx == exp_idx, "R2 allocation index",
            {alloc_grant, alloc_idx}, {1'b1, exp_idx});
    endtask

    task automatic complete(input logic [2:0] i, input logic [31:0] v, input logic m, input logic e);
        @(negedge clk); clr();
        cmpl_en = 1; cmpl_idx = i; cmpl_value = v; cmpl_mispredict = m; cmpl_exception = e;
    endtask

    task automatic expect_commit(input logic [1:0] k, input logic [4:0] d, input logic [31:0] v,
                                 input logic we, input logic st, input logic fl, input logic ex);
        sb.push_back({k, d, v, we, st, fl, ex});
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            #3;
            if (rst_n && commit_valid) begin
                if (sb.size() == 0) begin
                    chk(1'b0, "R3 retirement with nothing expected", {commit_kind, commit_dst}, 0);
                end else begin
                    logic [42:0] e;
                    logic [42:0] a;
                    e = sb.pop_front();
                    a = {commit_kind, commit_dst, commit_value, commit_reg_we,
                         commit_store, flush, exc_raise};
                    chk(a == e, "R4 R7 R8 retirement record", a, e);
                end
            end
        end
    end

    task automatic run_all();
        // R1 reset state
        clr();
        repeat (2) @(negedge clk);
        #2;
        chk(!commit_valid && !flush && !exc_raise, "R1 idle during reset",
            {commit_valid, flush, exc_raise}, 0);
        @(negedge clk); rst_n = 1;

        // program order: reg, store, branch (kind codes 0, 1, 2)
        alloc(2'd0, 5'd3, 3'd0);
        alloc(2'd1, 5'd9, 3'd1);
        alloc(2'd2, 5'd0, 3'd2);
        complete(3'd1, 32'h11, 0, 0);
        @(negedge clk); clr(); look_a_idx = 1; look_b_idx = 0;
        #2;
        chk(look_a_ready && look_a_value == 32'h11, "R5 completed slot readable",
            {look_a_ready, look_a_value}, {1'b1, 32'h11});
        chk(!look_b_ready, "R5 incomplete slot not ready", look_b_ready, 0);
        chk(!commit_valid, "R3 younger result waits behind head", commit_valid, 0);

        // R6: completion seen by lookup in the same cycle
        @(negedge clk); clr();
        cmpl_en = 1; cmpl_idx = 0; cmpl_value = 32'hAA; look_a_idx = 0;
        #2;
        chk(look_a_ready && look_a_value == 32'hAA, "R6 same-cycle forward",
            {look_a_ready, look_a_value}, {1'b1, 32'hAA});
        expect_commit(2'd0, 5'd3, 32'hAA, 1, 0, 0, 0);
        expect_commit(2'd1, 5'd9, 32'h11, 0, 1, 0, 0);
        complete(3'd2, 32'h22, 0, 0);
        expect_commit(2'd2, 5'd0, 32'h22, 0, 0, 0, 0);
        repeat (3) begin @(negedge clk); clr(); end
        #2;
        chk(!commit_valid, "R3 idle when empty", commit_valid, 0);

        // fill all eight slots, wrapping the index (R2)
        for (int i = 0; i < 8; i++) begin
            logic [2:0] ix;
            ix = 3'(3 + i);
            alloc((ix == 3'd5) ? 2'd2 : 2'd0, 5'(10 + ix), ix);
        end
        @(negedge clk); clr(); alloc_req = 1;
        #2;
        chk(!alloc_grant, "R2 refused when full", alloc_grant, 0);

        // mispredicted branch in slot 5 (R7)
        complete(3'd3, 32'h33, 0, 0);
        expect_commit(2'd0, 5'd13, 32'h33, 1, 0, 0, 0);
        complete(3'd4, 32'h44, 0, 0);
        expect_commit(2'd0, 5'd14, 32'h44, 1, 0, 0, 0);
        complete(3'd5, 32'h55, 1, 0);
        expect_commit(2'd2, 5'd15, 32'h55, 0, 0, 1, 0);
        @(negedge clk); clr();
        cmpl_en = 1; cmpl_idx = 6; cmpl_value = 32'h66; alloc_req = 1; look_a_idx = 6;
        #2;
        chk(flush && !alloc_grant, "R10 no grant in flush cycle",
            {flush, alloc_grant}, 2'b10);
        chk(look_a_ready && look_a_value == 32'h66, "R6 forward during flush",
            {look_a_ready, look_a_value}, {1'b1, 32'h66});
        @(negedge clk); clr(); look_a_idx = 6;
        #2;
        chk(!look_a_ready, "R7 younger slot discarded", look_a_ready, 0);
        chk(alloc_idx == 3'd6, "R7 next index after branch", alloc_idx, 3'd6);
        chk(!commit_valid, "R7 nothing left to retire", commit_valid, 0);

        // exception at slot 6 with a completed younger slot 7 (R8), stray completion (R9)
        alloc(2'd0, 5'd7, 3'd6);
        alloc(2'd0, 5'd8, 3'd7);
        complete(3'd0, 32'h99, 0, 0);
        @(negedge clk); clr(); look_a_idx = 0;
        #2;
        chk(!look_a_ready, "R9 stray completion ignored", look_a_ready, 0);
        complete(3'd7, 32'h77, 0, 0);
        complete(3'd6, 32'h60, 0, 1);
        expect_commit(2'd0, 5'd7, 32'h60, 0, 0, 1, 1);
        @(negedge clk); clr();
        @(negedge clk); clr(); look_a_idx = 7;
        #2;
        chk(!look_a_ready, "R8 younger slot discarded", look_a_ready, 0);
        chk(alloc_idx == 3'd7 && !commit_valid, "R8 buffer emptied",
            {alloc_idx, commit_valid}, {3'd7, 1'b0});
        repeat (3) begin @(negedge clk); clr(); end
        chk(sb.size() == 0, "R3 all expected retirements seen", sb.size(), 0);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (5000) @(posedge clk);
                chk(1'b0, "watchdog expired", 0, 1);
            end
        join_any
        disable fork;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule